// File: doc/BRIEF.md
# Multichannel SAR Conversion Sequencer

This block holds the digital side of an 8-bit successive-approximation converter that serves eight multiplexed inputs. A start comes from software, through a write to the status address, or from a rising edge on an external trigger pin when that source is enabled. The block selects a channel, runs a sample phase, and then resolves the result one bit at a time, most significant bit first. For each bit it drives a trial code to the DAC and reads back a single comparator bit. When a conversion finishes, the result goes into a data register that belongs to that channel.

In single mode only the programmed start channel is converted. In autoscan mode the block converts every channel from the start channel up to channel 7 in rising order, then stops and raises an end-of-conversion flag. A 3-bit prescaler sets the pace. At the fastest setting one conversion lasts 138 clock cycles, and the slowest setting is sixteen times longer.

Top module: `sar_seq`

## Requirements
- R1: After reset, every readable register returns 0, including all data registers, the control register (address 8) and the status register (address 9). `busy_o`, `eoc_o` and `sample_o` are low, and `dac_o` is 0.
- R2: A conversion produces the 8-bit code that matches the comparator, which reports 1 when the input is at or above `dac_o`. The first trial code after the sample phase is 0x80. The bits are resolved from MSB to LSB, and the codes 0x00 and 0xFF are reached exactly.
- R3: When control bit 3 (autoscan) is 0, only the channel in control bits [2:0] is converted, and every other data register keeps its value.
- R4: When control bit 3 is 1, channels from the start channel to 7 are converted in rising order, with `ch_o` stepping by +1. The sequence stops after channel 7, and starting at 7 converts one channel.
- R5: Control bits [6:4] hold the prescaler value p. One conversion lasts 138·d clock cycles, where d = 1 for p = 7 and d = 2·(8−p) otherwise. A sequence of n channels ends exactly n·138·d cycles after the start edge.
- R6: Each conversion begins with a sample phase of 80·d cycles, during which `sample_o` is high. `sample_o` is low while the block is idle.
- R7: Writing a 1 to bit 0 of address 9 starts a sequence.
- R8: A rising edge on `trig_ext_i` starts a sequence only when control bit 7 is 1. When that bit is 0, the edge is ignored.
- R9: Status bit 0 (`eoc_o`) goes high in the cycle the last result of a sequence is written and is cleared by the next accepted start. Status bit 1 is `busy_o`.
- R10: A start from either source that arrives while `busy_o` is high is ignored. The sequence length and its results are unchanged.
- R11: Addresses 0 to 7 read the channel data registers. Address 8 reads back the control register as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| trig_ext_i | input | 1 | External trigger, rising-edge active |
| cmp_i | input | 1 | Comparator result: input ≥ DAC code |
| dac_o | output | 8 | Trial code to the DAC |
| ch_o | output | 3 | Multiplexer channel select |
| sample_o | output | 1 | Sample-and-hold phase active |
| busy_o | output | 1 | Sequence in progress |
| eoc_o | output | 1 | End of sequence flag |

## Verification
The bench measures every sequence length to the exact cycle at several prescaler values. A divider that is off by one, or a phase that is one tick too long, therefore shows up as a wrong count. Full-scale and zero input codes are converted, so a design that drops the last bit decision or tests the wrong bit order returns a wrong code. Autoscan is started at channel 0, in the middle of the range and at channel 7, and all eight data registers are read after each run. This catches a scan that wraps, stops early or writes to a neighbouring register. Starts are injected from both sources in the middle of a conversion, and an external edge is given while that source is disabled. A design that restarts or extends a sequence in these cases fails the cycle count or the busy check.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NCH          = 8,
  parameter int DW           = 8,
  parameter int SAMPLE_TICKS = 80,
  parameter int BIT_TICKS    = 7,
  parameter int TAIL_TICKS   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [3:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          trig_ext_i,
  input  logic          cmp_i,
  output logic [DW-1:0] dac_o,
  output logic [2:0]    ch_o,
  output logic          sample_o,
  output logic          busy_o,
  output logic          eoc_o
);
  localparam int CW = $clog2(NCH);
  localparam int PW = $clog2(SAMPLE_TICKS + 1);
  localparam logic [3:0] A_CTRL = 4'(NCH);
  localparam logic [3:0] A_STAT = 4'(NCH + 1);

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_CONV, S_TAIL} st_t;
  st_t st;

  logic [CW-1:0] start_ch, cur_ch;
  logic          auto_en, ext_en, ext_q;
  logic [2:0]    pr;
  logic [3:0]    pre_cnt, div_m1;
  logic [PW-1:0] ph;
  logic [DW-1:0] sar, mask;
  logic [DW-1:0] res [NCH];
  logic          tick, go, sw_start, ext_rise, wr_res;

  assign busy_o   = (st != S_IDLE);
  assign sample_o = (st == S_SAMP);
  assign ch_o     = cur_ch;
  assign dac_o    = (st == S_CONV) ? (sar | mask) : sar;
  assign div_m1   = (pr == 3'd7) ? 4'd0 : {~pr, 1'b1};
  assign tick     = busy_o && (pre_cnt == div_m1);
  assign sw_start = bus_we && (bus_addr == A_STAT) && bus_wdata[0];
  assign ext_rise = ext_en && trig_ext_i && !ext_q;
  assign go       = (sw_start || ext_rise) && !busy_o;
  assign wr_res   = tick && (st == S_TAIL) && (ph == PW'(TAIL_TICKS - 1));

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < 4'(NCH))      bus_rdata = 8'(res[bus_addr[CW-1:0]]);
    else if (bus_addr == A_CTRL) bus_rdata = {ext_en, pr, auto_en, start_ch};
    else if (bus_addr == A_STAT) bus_rdata = {6'd0, busy_o, eoc_o};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_ch <= '0;
      auto_en  <= 1'b0;
      pr       <= 3'd0;
      ext_en   <= 1'b0;
      ext_q    <= 1'b0;
    end else begin
      ext_q <= trig_ext_i;
      if (bus_we && bus_addr == A_CTRL)
        {ext_en, pr, auto_en, start_ch} <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) res[i] <= '0;
    end else if (wr_res) begin
      res[cur_ch] <= sar;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cur_ch  <= '0;
      pre_cnt <= '0;
      ph      <= '0;
      sar     <= '0;
      mask    <= '0;
      eoc_o   <= 1'b0;
    end else if (go) begin
      st      <= S_SAMP;
      cur_ch  <= start_ch;
      pre_cnt <= '0;
      ph      <= '0;
      sar     <= '0;
      mask    <= DW'(1) << (DW - 1);
      eoc_o   <= 1'b0;
    end else if (busy_o) begin
      pre_cnt <= tick ? 4'd0 : pre_cnt + 4'd1;
      if (tick) begin
        case (st)
          S_SAMP:
            if (ph == PW'(SAMPLE_TICKS - 1)) begin
              ph <= '0;
              st <= S_CONV;
            end else ph <= ph + 1'b1;
          S_CONV:
            if (ph == PW'(BIT_TICKS - 1)) begin
              ph <= '0;
              if (cmp_i) sar <= sar | mask;
              mask <= mask >> 1;
              if (mask[0]) st <= S_TAIL;
            end else ph <= ph + 1'b1;
          S_TAIL:
            if (ph == PW'(TAIL_TICKS - 1)) begin
              ph <= '0;
              if (auto_en && cur_ch != CW'(NCH - 1)) begin
                cur_ch <= cur_ch + 1'b1;
                st     <= S_SAMP;
                sar    <= '0;
                mask   <= DW'(1) << (DW - 1);
              end else begin
                st    <= S_IDLE;
                eoc_o <= 1'b1;
              end
            end else ph <= ph + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_IDLE_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sample_o && dac_o == '0 || !busy_o && !sample_o); // R6
  AST_EOC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |-> !busy_o); // R9
  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && ch_o != $past(ch_o)) |-> ch_o == $past(ch_o) + 1'b1); // R4
  AST_BUSY_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && sw_start && !tick) |=> busy_o && $stable(ch_o) && !eoc_o); // R10
  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sample_o) && !sample_o && busy_o) |-> dac_o == (DW'(1) << (DW - 1))); // R2
  AST_EOC_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && !busy_o) |-> eoc_o); // R9
endmodule

// File: tb/test_sar_seq.sv
module test_sar_seq;
  logic       clk = 0, rst_n = 0;
  logic       bus_we = 0, trig_ext = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, dac;
  logic [2:0] ch;
  logic       sample, busy, eoc, cmp;
  logic [7:0] vin [8];
  logic [7:0] model [8];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;
  assign cmp = (vin[ch] >= dac);

  sar_seq i_sar_seq (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_ext_i(trig_ext),
    .cmp_i(cmp), .dac_o(dac), .ch_o(ch), .sample_o(sample),
    .busy_o(busy), .eoc_o(eoc));

  // {start[2:0], autoscan, prescaler[2:0]}
  localparam logic [6:0] VEC [6] = '{
    {3'd0, 1'b1, 3'd7}, {3'd3, 1'b1, 3'd7}, {3'd7, 1'b1, 3'd6},
    {3'd5, 1'b0, 3'd0}, {3'd0, 1'b1, 3'd5}, {3'd2, 1'b0, 3'd7}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; #2; d = bus_rdata;
  endtask

  function automatic int divof(input logic [2:0] p);
    return (p == 3'd7) ? 1 : 2 * (8 - p);
  endfunction

  task automatic check_regs(input string tag);
    logic [7:0] d;
    for (int c = 0; c < 8; c++) begin
      rd(4'(c), d);
      chk(d == model[c], tag, d, model[c]);
    end
  endtask

  // start and count cycles until eoc; disturb >= 0 injects both triggers then
  task automatic run(input bit ext, input int disturb, output int n);
    if (ext) begin
      @(negedge clk); trig_ext = 1;
      @(negedge clk); trig_ext = 0;
    end else wr(4'(9), 8'h01);
    n = 0;
    while (!eoc && n < 40000) begin
      if (n == disturb) begin bus_we = 1; bus_addr = 4'(9); bus_wdata = 8'h01; trig_ext = 1; end
      if (n == disturb + 1) begin bus_we = 0; trig_ext = 0; end
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, cnt;
    for (int c = 0; c < 8; c++) begin vin[c] = 0; model[c] = 0; end
    #45;
    // R1 reset state
    check_regs("R1 data");
    rd(4'd8, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(4'd9, d); chk(d == 0, "R1 status", d, 0);
    chk(!busy && !eoc && !sample && dac == 0, "R1 outputs", {busy, eoc, sample}, 0);
    rst_n = 1;

    // vector table: R2 R3 R4 R5 R7 R11
    for (int v = 0; v < 6; v++) begin
      logic [2:0] s = VEC[v][6:4];
      logic       au = VEC[v][3];
      logic [2:0] p = VEC[v][2:0];
      int nch = au ? 8 - s : 1;
      for (int c = 0; c < 8; c++) vin[c] = 8'(c * 53 + v * 29 + 17);
      wr(4'd8, {1'b0, p, au, s});
      rd(4'd8, d); chk(d == {1'b0, p, au, s}, "R11 ctrl readback", d, {1'b0, p, au, s});
      run(0, -1, n);
      chk(n == nch * 138 * divof(p), "R5 R4 R3 R7 sequence length", n, nch * 138 * divof(p));
      for (int c = 0; c < 8; c++) if (c >= s && c < s + nch) model[c] = vin[c];
      check_regs("R2 R3 R4 results");
      rd(4'd9, d); chk(d == 8'h01, "R9 status eoc", d, 1);
    end

    // R9 eoc cleared by new start; R6 sample phase; R2 first trial and extremes
    for (int c = 0; c < 8; c++) vin[c] = 8'hFF;
    wr(4'd8, {1'b0, 3'd6, 1'b0, 3'd4});
    wr(4'd9, 8'h01);
    chk(!eoc && busy, "R9 eoc cleared on start", eoc, 0);
    cnt = 0;
    while (sample && cnt < 1000) begin cnt++; @(negedge clk); end
    chk(cnt == 80 * 4, "R6 sample length", cnt, 320);
    chk(dac == 8'h80, "R2 first trial", dac, 8'h80);
    while (!eoc) @(negedge clk);
    model[4] = 8'hFF;
    check_regs("R2 full scale");
    for (int c = 0; c < 8; c++) vin[c] = 8'h00;
    wr(4'd8, {1'b0, 3'd7, 1'b1, 3'd6});
    run(0, -1, n);
    chk(n == 2 * 138, "R4 R5 two channels", n, 276);
    model[6] = 0; model[7] = 0;
    check_regs("R2 zero");
    chk(!sample, "R6 idle no sample", sample, 0);

    // R8 external trigger disabled
    for (int c = 0; c < 8; c++) vin[c] = 8'(c * 7 + 100);
    wr(4'd8, {1'b0, 3'd7, 1'b0, 3'd1});
    @(negedge clk); trig_ext = 1;
    @(negedge clk); trig_ext = 0;
    repeat (4) @(negedge clk);
    chk(!busy && eoc, "R8 ext ignored when disabled", busy, 0);
    check_regs("R8 no data change");

    // R8 external trigger enabled
    wr(4'd8, {1'b1, 3'd7, 1'b0, 3'd1});
    run(1, -1, n);
    chk(n == 138, "R8 ext start length", n, 138);
    model[1] = vin[1];
    check_regs("R8 ext results");

    // R10 triggers while busy
    wr(4'd8, {1'b1, 3'd7, 1'b1, 3'd5});
    run(0, 200, n);
    chk(n == 3 * 138, "R10 length unchanged", n, 414);
    model[5] = vin[5]; model[6] = vin[6]; model[7] = vin[7];
    check_regs("R10 results");
    repeat (3) @(negedge clk);
    chk(!busy && eoc, "R10 no restart", busy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule